// File: doc/BRIEF.md
# Bus Clock Ratio Divider Tree

This block turns one fast source clock into three clock-enable streams for a main bus, a high-speed bus and a peripheral bus. Each enable is high for exactly one source cycle per period of its bus. The two slower enables are built by counting main-bus enables, not source edges. As a result, every high-speed or peripheral enable falls in a cycle where the main enable is also high. Downstream logic uses these enables to advance its registers at the derived bus rate while staying on the single source clock.

Software writes a 16-bit configuration word together with a profile bit and a one-cycle load strobe. There are two profiles. The system profile takes the main ratio as the product of two linear factors, a high-speed code with one forbidden value, and a linear peripheral ratio. The peripheral-domain profile takes a single linear main divider and power-of-two ratios for the two slower buses. A legal word is held as pending. It becomes active only at the next cycle in which all three enables fire together, and all counters restart there. An illegal word is dropped and sets a sticky error flag. The reset configuration divides the source by 2 for the main bus, by 4 for the high-speed bus and by 8 for the peripheral bus. With a 594 MHz source this gives 297, 148.5 and 74.25 MHz.

Top module: `busclk_ratio_tree`

## Requirements
- R1: After reset, main_en pulses on every 2nd source cycle, fast_en on every 4th and per_en on every 8th. The first main_en falls in the second cycle after reset is released, and cfg_err is low.
- R2: With cfg_profile=0 (system), the main ratio in source cycles is (word[7:3]+1)*(word[2:0]+1).
- R3: With cfg_profile=0, word[9:8] codes 0, 1 and 3 select a high-speed period of 1, 2 and 4 main periods.
- R4: With cfg_profile=0, the peripheral period is word[14:12]+1 main periods.
- R5: With cfg_profile=1 (peripheral domain), the main ratio is word[4:0]+1 source cycles, and word[7:5] is ignored.
- R6: With cfg_profile=1, the high-speed period is 2^word[9:8] main periods for codes 0..2. The peripheral period is 2^word[14:12] main periods for fields 0..3.
- R7: A load is illegal when cfg_profile=0 with word[9:8]=2, or cfg_profile=1 with word[9:8]=3, or cfg_profile=1 with word[14:12]>=4. An illegal load changes no ratio and leaves any pending word intact. It sets cfg_err from the next cycle on, and cfg_err stays set until reset.
- R8: fast_en and per_en are only ever high in a cycle where main_en is high.
- R9: A legal load takes effect in the cycle after the next cycle in which main_en, fast_en and per_en are all high, with all phases restarted from zero. If several legal loads arrive before that point, the last one wins.
- R10: An enable whose total ratio is 1 stays high continuously. Otherwise each enable pulse lasts one source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that samples cfg_profile and cfg_word |
| cfg_profile | input | 1 | 0 = system profile, 1 = peripheral-domain profile |
| cfg_word | input | 16 | Divider fields |
| main_en | output | 1 | Main-bus clock enable |
| fast_en | output | 1 | High-speed-bus clock enable |
| per_en | output | 1 | Peripheral-bus clock enable |
| cfg_err | output | 1 | Sticky flag: an illegal word was loaded |

## Verification
The default ratios are checked first. Then system-profile words with unequal main factors are applied, so that swapping the two factor fields or dropping the +1 shows up in the main period. High-speed and peripheral ratios that are not multiples of each other (2 and 3) separate the cascade from any shared counter and fix where the joint boundary falls. All-ones ratios and a 1:1 main with a 4:1 high-speed ratio probe the continuous-high case. A group of three back-to-back loads, issued inside a long joint period, shows that nothing changes before the boundary and that the last word wins. The illegal codes of both profiles are sent after legal traffic, to show that the running ratios continue unchanged while the flag sets.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    // configuration word geometry
    localparam int CFG_W       = 16;
    localparam int MA_W        = 5;                 // system profile, first main factor
    localparam int MB_W        = 3;                 // system profile, second main factor
    localparam int PMAIN_W     = 5;                 // peripheral-domain main divider
    localparam int FAST_CODE_W = 2;
    localparam int PER_FLD_W   = 3;

    localparam int MB_LO    = 0;
    localparam int MA_LO    = MB_LO + MB_W;
    localparam int PMAIN_LO = 0;
    localparam int FAST_LO  = 8;
    localparam int PER_LO   = 12;

    // terminal-count widths of the three dividers
    localparam int MAIN_TC_W = MA_W + MB_W;
    localparam int FAST_TC_W = 2;
    localparam int PER_TC_W  = 3;

    typedef enum logic {
        PROF_SYS  = 1'b0,
        PROF_PERI = 1'b1
    } profile_e;

    typedef struct packed {
        logic [MAIN_TC_W-1:0] main_tc;
        logic [FAST_TC_W-1:0] fast_tc;
        logic [PER_TC_W-1:0]  per_tc;
    } ratio_cfg_t;

    // reset: source/2 main, main/2 high-speed, main/4 peripheral
    localparam ratio_cfg_t CFG_RESET = '{
        main_tc: MAIN_TC_W'(1),
        fast_tc: FAST_TC_W'(1),
        per_tc:  PER_TC_W'(3)
    };

    // 2^e - 1 for a power-of-two ratio exponent
    function automatic logic [PER_TC_W-1:0] pow2_minus1(input logic [1:0] e);
        logic [PER_TC_W-1:0] r;
        case (e)
            2'd0:    r = PER_TC_W'(0);
            2'd1:    r = PER_TC_W'(1);
            2'd2:    r = PER_TC_W'(3);
            default: r = PER_TC_W'(7);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcd_cfg_decode.sv
module bcd_cfg_decode
    import bcd_pkg::*;
(
    input  logic             profile,
    input  logic [CFG_W-1:0] word,
    output ratio_cfg_t       cfg,
    output logic             legal
);

    logic [MAIN_TC_W:0]       fa;
    logic [MAIN_TC_W:0]       fb;
    logic [MAIN_TC_W:0]       prod;
    logic [FAST_CODE_W-1:0]   fast_code;
    logic [PER_FLD_W-1:0]     per_fld;
    profile_e                 prof;
    logic                     unused_bits;

    assign unused_bits = ^{word[15], word[11:10]};
    assign prof        = profile_e'(profile);
    assign fast_code   = word[FAST_LO +: FAST_CODE_W];
    assign per_fld     = word[PER_LO +: PER_FLD_W];

    always_comb begin
        fa   = (MAIN_TC_W+1)'(word[MA_LO +: MA_W]) + (MAIN_TC_W+1)'(1);
        fb   = (MAIN_TC_W+1)'(word[MB_LO +: MB_W]) + (MAIN_TC_W+1)'(1);
        prod = fa * fb;
        cfg  = CFG_RESET;
        if (prof == PROF_PERI) begin
            legal       = (fast_code != 2'd3) && !per_fld[2];
            cfg.main_tc = MAIN_TC_W'(word[PMAIN_LO +: PMAIN_W]);
            cfg.fast_tc = FAST_TC_W'(pow2_minus1(fast_code));
            cfg.per_tc  = pow2_minus1(per_fld[1:0]);
        end else begin
            legal       = (fast_code != 2'd2);
            cfg.main_tc = MAIN_TC_W'(prod - (MAIN_TC_W+1)'(1));
            cfg.fast_tc = fast_code;          // codes 0,1,3 are already ratio-1
            cfg.per_tc  = per_fld;
        end
    end

endmodule

// File: rtl/bcd_cfg_hold.sv
module bcd_cfg_hold
    import bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       legal,
    input  ratio_cfg_t dec_cfg,
    input  logic       align,
    output ratio_cfg_t act_cfg,
    output logic       err
);

    ratio_cfg_t pend_q;
    logic       pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg  <= CFG_RESET;
            pend_q   <= CFG_RESET;
            pend_vld <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (align && pend_vld)
                act_cfg <= pend_q;
            if (load && legal) begin
                pend_q   <= dec_cfg;
                pend_vld <= 1'b1;
            end else if (align) begin
                pend_vld <= 1'b0;
            end
            if (load && !legal)
                err <= 1'b1;
        end
    end

    // R7: the error flag never clears outside reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R7: an illegal word leaves the pending set untouched and raises the flag
    p_illegal_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (load && !legal) |=> ($stable(pend_q) && err));

    // R9: active ratios move only at a joint boundary
    p_active_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !align |=> $stable(act_cfg));

endmodule

// File: rtl/bcd_ratio_ctr.sv
module bcd_ratio_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [CW-1:0] tc,
    output logic          hit
);

    logic [CW-1:0] cnt;

    assign hit = step && (cnt == tc);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= (cnt == tc) ? '0 : cnt + CW'(1);
    end

    // R10: the phase never runs past the active terminal count
    p_cnt_within_tc_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= tc);

endmodule

// File: rtl/busclk_ratio_tree.sv
module busclk_ratio_tree
    import bcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_profile,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             main_en,
    output logic             fast_en,
    output logic             per_en,
    output logic             cfg_err
);

    ratio_cfg_t dec_cfg;
    ratio_cfg_t act_cfg;
    logic       dec_legal;
    logic       align;

    assign align = fast_en && per_en;

    bcd_cfg_decode u_dec (
        .profile (cfg_profile),
        .word    (cfg_word),
        .cfg     (dec_cfg),
        .legal   (dec_legal)
    );

    bcd_cfg_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .legal   (dec_legal),
        .dec_cfg (dec_cfg),
        .align   (align),
        .act_cfg (act_cfg),
        .err     (cfg_err)
    );

    // main divider counts source edges
    bcd_ratio_ctr #(.CW(MAIN_TC_W)) u_main (
        .clk  (clk),
        .rst  (rst),
        .step (1'b1),
        .tc   (act_cfg.main_tc),
        .hit  (main_en)
    );

    // slower dividers count main-bus enables
    bcd_ratio_ctr #(.CW(FAST_TC_W)) u_fast (
        .clk  (clk),
        .rst  (rst),
        .step (main_en),
        .tc   (act_cfg.fast_tc),
        .hit  (fast_en)
    );

    bcd_ratio_ctr #(.CW(PER_TC_W)) u_per (
        .clk  (clk),
        .rst  (rst),
        .step (main_en),
        .tc   (act_cfg.per_tc),
        .hit  (per_en)
    );

    // R10: a main pulse is one source cycle wide unless the ratio is 1
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        (main_en && !align && (act_cfg.main_tc != '0)) |=> !main_en);

    // R8: peripheral enable lands on a main enable
    p_per_on_main_r8: assert property (@(posedge clk) disable iff (rst)
        per_en |-> main_en);

endmodule

// File: tb/busclk_ratio_tree_test.sv
module busclk_ratio_tree_test;

    localparam int PERIOD = 10;

    logic        clk;
    logic        rst;
    logic        cfg_load;
    logic        cfg_profile;
    logic [15:0] cfg_word;
    logic        main_en;
    logic        fast_en;
    logic        per_en;
    logic        cfg_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // reference model state: ratios in source cycles / main periods
    int am, af, ap;
    int pm, pf, pp;
    bit pv;
    bit merr;
    int t;

    busclk_ratio_tree uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .cfg_profile (cfg_profile),
        .cfg_word    (cfg_word),
        .main_en     (main_en),
        .fast_en     (fast_en),
        .per_en      (per_en),
        .cfg_err     (cfg_err)
    );

    initial begin
        clk = 1'b0;
        forever #(PERIOD/2) clk = ~clk;
    end

    function automatic logic [15:0] sysw(int per, int fast, int a, int b);
        logic [15:0] w = '0;
        w[14:12] = per[2:0];
        w[9:8]   = fast[1:0];
        w[7:3]   = a[4:0];
        w[2:0]   = b[2:0];
        return w;
    endfunction

    function automatic logic [15:0] periw(int per, int fast, int m, int junk);
        logic [15:0] w = '0;
        w[14:12] = per[2:0];
        w[9:8]   = fast[1:0];
        w[7:5]   = junk[2:0];
        w[4:0]   = m[4:0];
        return w;
    endfunction

    // decode from the requirement text
    function automatic bit ref_decode(input bit prof, input logic [15:0] w,
                                      output int m, output int f, output int p);
        int code = int'(w[9:8]);
        int pfld = int'(w[14:12]);
        m = 1; f = 1; p = 1;
        if (!prof) begin
            m = (int'(w[7:3]) + 1) * (int'(w[2:0]) + 1);
            p = pfld + 1;
            if (code == 2) return 1'b0;
            f = (code == 3) ? 4 : code + 1;
            return 1'b1;
        end
        m = int'(w[4:0]) + 1;
        if (code == 3 || pfld >= 4) return 1'b0;
        f = 1 << code;
        p = 1 << pfld;
        return 1'b1;
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, then model advance on the inputs the next edge samples
    always @(negedge clk) begin
        if (rst) begin
            am = 2; af = 2; ap = 4;
            pm = 2; pf = 2; pp = 4;
            pv = 0; merr = 0; t = 0;
        end else begin
            bit em, ef, ep;
            em = ((t + 1) % am) == 0;
            ef = ((t + 1) % (am * af)) == 0;
            ep = ((t + 1) % (am * ap)) == 0;
            n_cmp++;
            if ({main_en, fast_en, per_en, cfg_err} !== {em, ef, ep, merr}) begin
                n_bad++;
                $display("FAIL %s t=%0d main/fast/per/err: actual %b%b%b%b expected %b%b%b%b",
                         cur_req, t, main_en, fast_en, per_en, cfg_err, em, ef, ep, merr);
            end
            if ((fast_en || per_en) && !main_en) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R8 slow enable without main: actual main_en=%b expected 1", main_en);
            end
            if (ef && ep) begin
                t = 0;
                if (pv) begin
                    am = pm; af = pf; ap = pp; pv = 0;
                end
            end else begin
                t++;
            end
            if (cfg_load) begin
                int m, f, p;
                if (ref_decode(cfg_profile, cfg_word, m, f, p)) begin
                    pm = m; pf = f; pp = p; pv = 1;
                end else begin
                    merr = 1;
                end
            end
        end
    end

    task automatic load(bit prof, logic [15:0] w);
        @(posedge clk); #1;
        cfg_profile = prof;
        cfg_word    = w;
        cfg_load    = 1'b1;
        @(posedge clk); #1;
        cfg_load    = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_load = 1'b0; cfg_profile = 1'b0; cfg_word = '0;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", main_en, 1'b0, "first cycle main_en");
        chk("R1", cfg_err, 1'b0, "cfg_err after reset");
        @(negedge clk);
        chk("R1", main_en, 1'b1, "second cycle main_en");
        run(40);

        // R2, R3, R4: factors 3 and 2, high-speed 2, peripheral 3
        cur_req = "R2";
        load(1'b0, sysw(2, 1, 2, 1));
        run(200);
        cur_req = "R4";
        load(1'b0, sysw(7, 0, 4, 2));
        run(400);
        // R10: main 1:1 with high-speed 4:1
        cur_req = "R10";
        load(1'b0, sysw(0, 3, 0, 0));
        run(80);
        cur_req = "R3";
        load(1'b0, sysw(1, 3, 0, 2));
        run(150);
        chk("R7", cfg_err, 1'b0, "no error after legal loads");

        // R7: system-profile forbidden high-speed code
        cur_req = "R7";
        load(1'b0, sysw(1, 2, 5, 5));
        @(negedge clk);
        chk("R7", cfg_err, 1'b1, "error after illegal code");
        run(150);

        // R5, R6: peripheral domain, word[7:5] junk
        cur_req = "R5";
        load(1'b1, periw(3, 2, 2, 5));
        run(300);
        cur_req = "R6";
        load(1'b1, periw(2, 1, 1, 0));
        run(200);
        cur_req = "R7";
        load(1'b1, periw(0, 3, 0, 0));
        run(40);
        load(1'b1, periw(5, 0, 0, 0));
        run(60);
        chk("R7", cfg_err, 1'b1, "error stays set");

        // R10: every ratio 1
        cur_req = "R10";
        load(1'b1, periw(0, 0, 0, 0));
        run(20);
        @(negedge clk);
        chk("R10", main_en && fast_en && per_en, 1'b1, "all enables held high");

        // R9: long joint period, then three loads before the boundary
        cur_req = "R9";
        load(1'b0, sysw(7, 3, 3, 0));
        run(6);
        load(1'b0, sysw(1, 1, 1, 1));
        load(1'b0, sysw(2, 0, 0, 1));
        load(1'b1, periw(2, 1, 1, 0));
        run(250);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule